// File: doc/BRIEF.md
# Register-Controlled Reset Generator

This block produces 64 independent reset lines for the rest of a chip. Software drives it through a small register port: two 32-bit control words carry one bit per line, and two 32-bit status words report, per line, whether that line is active. Writing a 1 into a control bit starts a reset on the matching line. Most lines end their reset on their own after a fixed, parameterized number of clock cycles. Two lines (numbers 12 and 56) are instead held asserted until software writes a 0 into their bit.

A control write always updates all 32 bits of its word at once. A held line therefore drops whenever its word is rewritten with a 0 in its position. The status words are active-low, so software reads a status word, inverts it and ORs in the bits it wants. It can then rewrite a control word without losing the held lines. Line 0 also drives a dedicated whole-chip reset request output.

Top module: `reset_gen_unit`

## Requirements
- R1: The control words sit at byte addresses 0x100 (lines 0..31) and 0x104 (lines 32..63), and the status words at 0x150 and 0x154. Line N is bit N%32 of word N/32.
- R2: Writing a control word with bit k set makes line k active from the clock edge that takes the write. Both the line output and a status read in the following cycle show it.
- R3: A line other than 12 and 56 stays active for exactly PULSE_CYCLES clock cycles (default 16) after the write edge, then goes inactive with no further write.
- R4: Writing 1 again to a self-ending line whose pulse is still running restarts its full PULSE_CYCLES count from that write.
- R5: Writing 0 into the bit of a self-ending line does not shorten a pulse that is already running.
- R6: Lines 12 and 56 stay active after being set, for any length of time. Any write to their control word with 0 in their bit releases them, including a write aimed at other lines.
- R7: A status bit reads 0 while its line is active and 1 while it is inactive.
- R8: Reading a control word returns the current active state of its 32 lines, with 1 meaning active.
- R9: Reads from addresses other than the four mapped words return 0. Writes to any address other than the two control words, the status words included, change no line.
- R10: The whole-chip request output follows line 0 in every cycle.
- R11: A synchronous active-low reset makes every line inactive. Once it is released, both status words read 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| reg_addr | input | 12 | Byte address for both reads and writes |
| reg_wr_en | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| line_rst_o | output | 64 | Registered active-high reset lines |
| chip_rst_req_o | output | 1 | Whole-chip reset request, same as line 0 |

## Verification
The bench measures the exact pulse length, so a counter that is off by one, or an output taken from a stage too late, shows up as 15 or 17 cycles. It rewrites a running pulse with 1 and with 0. A design that ignores the restart ends early, and one that obeys the 0 cuts the pulse short. It releases a held line through a write meant for another bit of the same word, and it checks that writes to unmapped and status addresses leave the held line standing. A design that merges writes per bit, or that decodes addresses loosely, fails those checks. It also applies reset in the middle of a run with a held line active, which catches a latch that survives the block reset.

// File: rtl/rgu_pkg.sv
// Package: shared constants of the reset generator.
// Assumes byte addressing with a 4-byte stride between words.
package rgu_pkg;
    localparam int unsigned RGU_WORD_W     = 32;
    localparam int unsigned RGU_NUM_WORDS  = 2;
    localparam int unsigned RGU_ADDR_W     = 12;
    localparam int unsigned RGU_CTRL_BASE  = 32'h100;
    localparam int unsigned RGU_STAT_BASE  = 32'h150;
    localparam int unsigned RGU_WORD_STEP  = 4;
    localparam int unsigned RGU_PULSE_DEF  = 16;
    // Lines 12 and 56 are held until software releases them.
    localparam logic [63:0] RGU_HELD_DEF   = 64'h0100_0000_0000_1000;
endpackage

// File: rtl/rgu_reg_decode.sv
// Module: register decode for the reset generator.
// Turns a write into one strobe per control word, and builds combinational
// read data from the line states. Control words read the active state;
// status words read it inverted. Unmapped addresses read 0.
// Assumes that at most one word is written per cycle.
module rgu_reg_decode #(
    parameter int unsigned NUM_WORDS = rgu_pkg::RGU_NUM_WORDS,
    parameter int unsigned WORD_W    = rgu_pkg::RGU_WORD_W,
    parameter int unsigned ADDR_W    = rgu_pkg::RGU_ADDR_W,
    parameter int unsigned CTRL_BASE = rgu_pkg::RGU_CTRL_BASE,
    parameter int unsigned STAT_BASE = rgu_pkg::RGU_STAT_BASE,
    parameter int unsigned WORD_STEP = rgu_pkg::RGU_WORD_STEP
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [NUM_WORDS*WORD_W-1:0] line_state,
    output logic [NUM_WORDS-1:0]        word_wr_stb,
    output logic [WORD_W-1:0]           rdata
);
    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_stb
            localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_BASE + w * WORD_STEP);
            // Write strobe for control word w.
            assign word_wr_stb[w] = wr_en && (addr == CTRL_ADDR);
        end
    endgenerate

    // Read mux: control words, then status words, default zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (addr == ADDR_W'(CTRL_BASE + i * WORD_STEP))
                rdata = line_state[i*WORD_W +: WORD_W];
            if (addr == ADDR_W'(STAT_BASE + i * WORD_STEP))
                rdata = ~line_state[i*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/rgu_line.sv
// Module: one reset line with a registered output.
// HELD = 0: a write of 1 loads a down-counter, and the line stays active
//           for PULSE_CYCLES cycles; a write of 0 is ignored.
// HELD = 1: the line follows the written bit on every write to its word.
// Assumes wr_stb is high only in cycles that write this line's word.
module rgu_line #(
    parameter int unsigned PULSE_CYCLES = rgu_pkg::RGU_PULSE_DEF,
    parameter bit          HELD         = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic line_o
);
    localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

    logic line_q;
    assign line_o = line_q;

    generate
        if (HELD) begin : g_held
            // Held latch: take the written bit, otherwise keep the state.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    line_q <= 1'b0;
                else if (wr_stb)
                    line_q <= wr_bit;
            end
        end else begin : g_pulse
            logic [CNT_W-1:0] cnt_q;
            logic [CNT_W-1:0] cnt_nxt;

            // Next count: reload on a write of 1, else count down to zero.
            always_comb begin
                cnt_nxt = cnt_q;
                if (wr_stb && wr_bit)
                    cnt_nxt = CNT_LOAD;
                else if (cnt_q != '0)
                    cnt_nxt = cnt_q - 1'b1;
            end

            // Counter and glitch-free output register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    line_q <= 1'b0;
                end else begin
                    cnt_q  <= cnt_nxt;
                    line_q <= (cnt_nxt != '0);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/reset_gen_unit.sv
// Module: top of the register-controlled reset generator.
// Decodes the register port and instantiates one rgu_line per output.
// Bits of HELD_MASK pick held lines. Line 0 doubles as the whole-chip
// reset request. Assumes a single clock and a synchronous active-low reset.
module reset_gen_unit #(
    parameter int unsigned NUM_WORDS    = rgu_pkg::RGU_NUM_WORDS,
    parameter int unsigned WORD_W       = rgu_pkg::RGU_WORD_W,
    parameter int unsigned ADDR_W       = rgu_pkg::RGU_ADDR_W,
    parameter int unsigned CTRL_BASE    = rgu_pkg::RGU_CTRL_BASE,
    parameter int unsigned STAT_BASE    = rgu_pkg::RGU_STAT_BASE,
    parameter int unsigned WORD_STEP    = rgu_pkg::RGU_WORD_STEP,
    parameter int unsigned PULSE_CYCLES = rgu_pkg::RGU_PULSE_DEF,
    parameter logic [NUM_WORDS*WORD_W-1:0] HELD_MASK = rgu_pkg::RGU_HELD_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_wr_en,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic [NUM_WORDS*WORD_W-1:0] line_rst_o,
    output logic                        chip_rst_req_o
);
    localparam int unsigned NUM_LINES = NUM_WORDS * WORD_W;

    logic [NUM_WORDS-1:0] word_wr_stb;
    logic [NUM_LINES-1:0] line_state;

    rgu_reg_decode #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .CTRL_BASE (CTRL_BASE),
        .STAT_BASE (STAT_BASE),
        .WORD_STEP (WORD_STEP)
    ) i_decode (
        .addr        (reg_addr),
        .wr_en       (reg_wr_en),
        .line_state  (line_state),
        .word_wr_stb (word_wr_stb),
        .rdata       (reg_rdata)
    );

    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_line
            rgu_line #(
                .PULSE_CYCLES (PULSE_CYCLES),
                .HELD         (HELD_MASK[n])
            ) i_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_stb (word_wr_stb[n / WORD_W]),
                .wr_bit (reg_wdata[n % WORD_W]),
                .line_o (line_state[n])
            );
        end
    endgenerate

    assign line_rst_o     = line_state;
    assign chip_rst_req_o = line_state[0];
endmodule

// File: rtl/rgu_checker.sv
// Module: assertion checker for reset_gen_unit, attached by bind below.
// Assumes the same parameters as the top it watches.
module rgu_checker #(
    parameter int unsigned NUM_WORDS    = rgu_pkg::RGU_NUM_WORDS,
    parameter int unsigned WORD_W       = rgu_pkg::RGU_WORD_W,
    parameter int unsigned ADDR_W       = rgu_pkg::RGU_ADDR_W,
    parameter int unsigned CTRL_BASE    = rgu_pkg::RGU_CTRL_BASE,
    parameter int unsigned STAT_BASE    = rgu_pkg::RGU_STAT_BASE,
    parameter int unsigned WORD_STEP    = rgu_pkg::RGU_WORD_STEP,
    parameter logic [NUM_WORDS*WORD_W-1:0] HELD_MASK = rgu_pkg::RGU_HELD_DEF
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic                        reg_wr_en,
    input logic [WORD_W-1:0]           reg_wdata,
    input logic [WORD_W-1:0]           reg_rdata,
    input logic [NUM_WORDS*WORD_W-1:0] line_rst_o,
    input logic                        chip_rst_req_o
);
    localparam int unsigned NUM_LINES = NUM_WORDS * WORD_W;

    // Whether the current address hits any mapped word.
    logic addr_mapped;
    always_comb begin
        addr_mapped = 1'b0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (reg_addr == ADDR_W'(CTRL_BASE + i * WORD_STEP)) addr_mapped = 1'b1;
            if (reg_addr == ADDR_W'(STAT_BASE + i * WORD_STEP)) addr_mapped = 1'b1;
        end
    end

    genvar n, w;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_chk_line
            localparam logic [ADDR_W-1:0] MY_CTRL = ADDR_W'(CTRL_BASE + (n / WORD_W) * WORD_STEP);
            // R2: a written 1 shows on the line after the edge.
            p_set_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr_en && reg_addr == MY_CTRL && reg_wdata[n % WORD_W]) |=> line_rst_o[n]);
            if (HELD_MASK[n]) begin : g_held
                // R6: a held line survives any cycle without a write to its word.
                p_held_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    (line_rst_o[n] && !(reg_wr_en && reg_addr == MY_CTRL)) |=> line_rst_o[n]);
            end else begin : g_pulse
                // R3: a self-ending line never rises without a written 1.
                p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (!line_rst_o[n] && !(reg_wr_en && reg_addr == MY_CTRL && reg_wdata[n % WORD_W]))
                    |=> !line_rst_o[n]);
            end
        end
        for (w = 0; w < NUM_WORDS; w++) begin : g_chk_word
            localparam logic [ADDR_W-1:0] MY_STAT = ADDR_W'(STAT_BASE + w * WORD_STEP);
            // R7: status reads the inverse of the line states.
            p_status_inverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_addr == MY_STAT) |-> (reg_rdata == ~line_rst_o[w*WORD_W +: WORD_W]));
        end
    endgenerate

    // R9: unmapped reads return zero.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped |-> (reg_rdata == '0));

    // R10: the chip request mirrors line 0.
    p_chip_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req_o == line_rst_o[0]);

    // R11: a reset cycle leaves every line inactive.
    p_reset_clears_r11: assert property (@(posedge clk)
        !rst_n |=> (line_rst_o == '0));
endmodule

bind reset_gen_unit rgu_checker #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE),
    .STAT_BASE (STAT_BASE),
    .WORD_STEP (WORD_STEP),
    .HELD_MASK (HELD_MASK)
) i_rgu_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_wr_en      (reg_wr_en),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .line_rst_o     (line_rst_o),
    .chip_rst_req_o (chip_rst_req_o)
);

// File: tb/test_reset_gen_unit.sv
// Bench: vector table walked by one loop, then directed corner cases.
module test_reset_gen_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] line_rst_o;
    logic        chip_rst_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reset_gen_unit i_reset_gen_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_addr       (reg_addr),
        .reg_wr_en      (reg_wr_en),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .line_rst_o     (line_rst_o),
        .chip_rst_req_o (chip_rst_req_o)
    );

    // Each entry: write address, write data, read address, expected read.
    localparam logic [87:0] VECS [0:9] = '{
        {12'h100, 32'h0000_0001, 12'h100, 32'h0000_0001}, // R2 R8 line 0
        {12'h100, 32'h0000_1000, 12'h150, 32'hFFFF_EFFF}, // R7 held 12 set
        {12'h104, 32'h0100_0000, 12'h104, 32'h0100_0000}, // R1 held 56 set
        {12'h100, 32'h8000_0002, 12'h100, 32'h8000_0002}, // R6 12 released
        {12'h104, 32'h0100_0004, 12'h154, 32'hFEFF_FFFB}, // R7 56 kept
        {12'h1F0, 32'hFFFF_FFFF, 12'h100, 32'h0000_0000}, // R9 R3 expired
        {12'h108, 32'hFFFF_FFFF, 12'h104, 32'h0100_0000}, // R9 56 held
        {12'h150, 32'hFFFF_FFFF, 12'h154, 32'hFEFF_FFFF}, // R9 status write
        {12'h104, 32'h0000_0000, 12'h154, 32'hFFFF_FFFF}, // R6 56 released
        {12'h000, 32'h0000_0005, 12'h0C0, 32'h0000_0000}  // R9 unmapped read
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_addr  = '0;
    endtask

    task automatic read_at(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic count_high(input int k, output int n);
        n = 0;
        while (line_rst_o[k] && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 lines after reset", line_rst_o, 64'h0);
        read_at(12'h150, rd);
        check("R11 status0 after reset", {32'h0, rd}, {32'h0, 32'hFFFF_FFFF});
        read_at(12'h154, rd);
        check("R11 status1 after reset", {32'h0, rd}, {32'h0, 32'hFFFF_FFFF});

        // Vector table
        for (int i = 0; i < 10; i++) begin
            logic [11:0] wa, ra;
            logic [31:0] wd, re;
            {wa, wd, ra, re} = VECS[i];
            do_write(wa, wd);
            read_at(ra, rd);
            check($sformatf("R1 vector %0d read", i), {32'h0, rd}, {32'h0, re});
            repeat (20) @(negedge clk);
        end

        // R3 exact pulse length
        do_write(12'h100, 32'h0000_0020);
        count_high(5, cnt);
        check("R3 pulse length line 5", 64'(cnt), 64'd16);

        // R4 restart while running
        do_write(12'h104, 32'h0000_0080);
        repeat (10) @(negedge clk);
        do_write(12'h104, 32'h0000_0080);
        count_high(39, cnt);
        check("R4 restarted length line 39", 64'(cnt), 64'd16);

        // R5 writing 0 does not cut a running pulse
        do_write(12'h100, 32'h0000_0200);
        repeat (3) @(negedge clk);
        do_write(12'h100, 32'h0000_0000);
        check("R5 line 9 after zero write", {63'h0, line_rst_o[9]}, 64'h1);
        repeat (10) @(negedge clk);
        check("R5 line 9 at last cycle", {63'h0, line_rst_o[9]}, 64'h1);
        @(negedge clk);
        check("R3 line 9 ended", {63'h0, line_rst_o[9]}, 64'h0);

        // R10 chip request follows line 0
        do_write(12'h100, 32'h0000_0001);
        check("R10 chip request high", {63'h0, chip_rst_req_o}, 64'h1);
        repeat (20) @(negedge clk);
        check("R10 chip request low", {63'h0, chip_rst_req_o}, 64'h0);

        // R6 held line persists far beyond the pulse period
        do_write(12'h100, 32'h0000_1000);
        repeat (40) @(negedge clk);
        check("R6 line 12 still held", line_rst_o, 64'h0000_0000_0000_1000);

        // R11 reset in the middle of activity
        do_write(12'h104, 32'h0100_0008);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 lines cleared mid-run", line_rst_o, 64'h0);
        read_at(12'h154, rd);
        check("R11 status1 after mid-run reset", {32'h0, rd}, {32'h0, 32'hFFFF_FFFF});
        read_at(12'h100, rd);
        check("R8 ctrl0 after mid-run reset", {32'h0, rd}, 64'h0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule